// File: doc/BRIEF.md
# SPI NAND Command Frame Engine

This block runs one complete serial transaction to a NAND flash device over a single-lane SPI link in mode 0. A host hands it a command descriptor in one cycle: an opcode, how many address bytes to send and their values, how many dummy bytes to insert, a direction, and a data length. The engine then lowers chip select and shifts the frame out as four phases in a fixed order: opcode, address, dummy, data. Any of the last three may be empty.

Write data is pulled one byte at a time through a ready/valid handshake; the serial clock simply pauses while the host has nothing to offer. Read data comes back one byte at a time with a single-cycle valid strobe. Typical uses are a status or feature register read (opcode 0x0F, one address byte, one byte in), a feature write (0x1F, one address byte, one byte out), an identification read (0x9F, three bytes in), and page-cache loads or reads of up to a full page with its spare area.

Top module: `spinand_frame_engine`

## Requirements
- R1: After reset, spiCsN is 1, spiSclk is 0, and busy, done, rxValid and txReady are all 0.
- R2: Each frame starts with the opcode byte. Every byte goes out most significant bit first on spiMosi. spiMosi changes only while spiSclk is low, and the device samples it on the rising edge of spiSclk.
- R3: cmdAddrCnt (0 to 3) address bytes follow the opcode. They are the low cmdAddrCnt bytes of cmdAddr, sent from the highest of them down to cmdAddr[7:0]. With 3 bytes and 0x123456 the order is 0x12, 0x34, 0x56.
- R4: cmdDummyCnt (0 to 3) dummy bytes follow the address bytes, each one sent as 0xFF.
- R5: When cmdRx is 0, the data phase sends cmdLen bytes taken from txData, one byte for each cycle in which txReady and txValid are both high. While txReady is high and txValid is low, spiSclk stays low and spiCsN stays low.
- R6: When cmdRx is 1, the data phase receives cmdLen bytes from spiMiso, sampled on rising edges and assembled MSB first. Each byte appears on rxData with rxValid high for one cycle, and spiMosi sends 0xFF during this phase. rxValid and txReady are never both high.
- R7: spiCsN stays low from the first bit of a frame to the last. It then stays high for at least GAP_CYC+1 system clocks, and for exactly GAP_CYC+1 (3 by default) when the next command is presented in the cycle in which done is high.
- R8: One spiSclk period is 2*SCLK_HALF system clocks (4 by default). spiSclk is low whenever spiCsN is high.
- R9: done is high for exactly one cycle per command. In that cycle busy is 0 and spiCsN is 1. A command is accepted only while busy is 0, so cmdValid has no effect while a frame is in progress.
- R10: A cmdLen above MAX_LEN (2112) is treated as MAX_LEN.
- R11: A command with no address, no dummy and zero length produces exactly one byte, that is 8 spiSclk rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmdValid | input | 1 | Command present; taken while busy is 0 |
| cmdOpcode | input | 8 | Opcode byte |
| cmdAddrCnt | input | 2 | Number of address bytes, 0 to 3 |
| cmdAddr | input | 24 | Address bytes, low cmdAddrCnt bytes used |
| cmdDummyCnt | input | DUMMY_W | Number of 0xFF dummy bytes |
| cmdRx | input | 1 | 1 selects receive, 0 selects transmit |
| cmdLen | input | LEN_W | Data phase length in bytes |
| txData | input | 8 | Write data byte |
| txValid | input | 1 | Write data byte available |
| txReady | output | 1 | Engine takes txData this cycle if txValid |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | rxData valid, one cycle per byte |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| spiCsN | output | 1 | Chip select, active low |
| spiSclk | output | 1 | Serial clock, idle low |
| spiMosi | output | 1 | Serial data to device |
| spiMiso | input | 1 | Serial data from device |

## Verification
The end-of-command pulse and the acceptance of the next command can fall in the same cycle, because done rises just as the engine becomes idle. The bench provokes this by issuing a second command in the very cycle it sees done high. It then checks that the second frame is complete and correct, and that chip select stayed high for exactly GAP_CYC+1 clocks between the two frames. A second overlap, a write-data stall that lands on the first data byte, is judged by checking that both the serial clock and chip select hold steady for every stalled cycle.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_GAP
  } phase_t;

  // strobes from control to the bit shifter
  typedef struct packed {
    logic       load;
    logic [7:0] txByte;
  } dpCmd_t;

  // status from the bit shifter back to control
  typedef struct packed {
    logic       byteDone;
    logic [7:0] rxByte;
  } dpStat_t;

endpackage

// File: rtl/sfe_shift.sv
module sfe_shift
  import sfe_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  dpCmd_t  dpCmd,
  output dpStat_t dpStat,
  input  logic    spiMiso,
  output logic    spiSclk,
  output logic    spiMosi
);

  localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCLK_HALF - 1);

  logic [7:0]       shReg;
  logic [7:0]       rxSh;
  logic [2:0]       bitIdx;
  logic [DIV_W-1:0] divCnt;
  logic             sclkR;
  logic             active;
  logic             byteDoneR;
  logic             halfEnd;

  assign halfEnd = active && (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shReg     <= 8'hFF;
      rxSh      <= 8'h00;
      bitIdx    <= 3'd0;
      divCnt    <= '0;
      sclkR     <= 1'b0;
      active    <= 1'b0;
      byteDoneR <= 1'b0;
    end else begin
      byteDoneR <= 1'b0;
      if (dpCmd.load) begin
        shReg  <= dpCmd.txByte;
        bitIdx <= 3'd0;
        divCnt <= '0;
        sclkR  <= 1'b0;
        active <= 1'b1;
      end else if (active) begin
        if (halfEnd) begin
          divCnt <= '0;
          if (!sclkR) begin
            // rising edge: capture device data
            sclkR <= 1'b1;
            rxSh  <= {rxSh[6:0], spiMiso};
          end else begin
            // falling edge: move to the next bit or finish the byte
            sclkR <= 1'b0;
            if (bitIdx == 3'd7) begin
              active    <= 1'b0;
              byteDoneR <= 1'b1;
            end else begin
              bitIdx <= bitIdx + 3'd1;
              shReg  <= {shReg[6:0], 1'b1};
            end
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  assign spiSclk         = sclkR;
  assign spiMosi         = shReg[7];
  assign dpStat.byteDone = byteDoneR;
  assign dpStat.rxByte   = rxSh;

endmodule

// File: rtl/sfe_ctrl.sv
module sfe_ctrl
  import sfe_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int MAX_LEN = 2112,
  parameter int DUMMY_W = 2,
  parameter int GAP_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmdValid,
  input  logic [7:0]         cmdOpcode,
  input  logic [1:0]         cmdAddrCnt,
  input  logic [23:0]        cmdAddr,
  input  logic [DUMMY_W-1:0] cmdDummyCnt,
  input  logic               cmdRx,
  input  logic [LEN_W-1:0]   cmdLen,
  input  logic [7:0]         txData,
  input  logic               txValid,
  output logic               txReady,
  output logic               rxValid,
  output logic               busy,
  output logic               done,
  output logic               csN,
  output dpCmd_t             dpCmd,
  input  dpStat_t            dpStat
);

  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam logic [LEN_W-1:0] LEN_CAP  = LEN_W'(MAX_LEN);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);

  phase_t             state;
  phase_t             nextPh;
  logic [7:0]         opcReg;
  logic [23:0]        addrReg;
  logic [1:0]         addrLeft;
  logic [DUMMY_W-1:0] dummyLeft;
  logic [LEN_W-1:0]   dataLeft;
  logic               dirRx;
  logic               waitLoad;
  logic [GAP_W-1:0]   gapCnt;
  logic               csNR;
  logic               doneR;

  logic [1:0]         nAddr;
  logic [DUMMY_W-1:0] nDummy;
  logic [LEN_W-1:0]   nData;
  logic               byteAvail;
  logic [7:0]         outByte;

  // counts remaining after the byte now finishing
  assign nAddr  = addrLeft  - 2'(state == ST_ADDR);
  assign nDummy = dummyLeft - DUMMY_W'(state == ST_DUMMY);
  assign nData  = dataLeft  - LEN_W'(state == ST_DATA);

  always_comb begin
    if (nAddr != 2'd0)             nextPh = ST_ADDR;
    else if (nDummy != '0)         nextPh = ST_DUMMY;
    else if (nData != '0)          nextPh = ST_DATA;
    else                           nextPh = ST_GAP;
  end

  always_comb begin
    unique case (state)
      ST_OPC:   outByte = opcReg;
      ST_ADDR: begin
        case (addrLeft)
          2'd3:    outByte = addrReg[23:16];
          2'd2:    outByte = addrReg[15:8];
          default: outByte = addrReg[7:0];
        endcase
      end
      ST_DATA:  outByte = dirRx ? 8'hFF : txData;
      default:  outByte = 8'hFF;
    endcase
  end

  assign byteAvail    = waitLoad && ((state != ST_DATA) || dirRx || txValid);
  assign txReady      = waitLoad && (state == ST_DATA) && !dirRx;
  assign rxValid      = dpStat.byteDone && (state == ST_DATA) && dirRx;
  assign dpCmd.load   = byteAvail;
  assign dpCmd.txByte = outByte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      opcReg    <= 8'h00;
      addrReg   <= 24'h0;
      addrLeft  <= 2'd0;
      dummyLeft <= '0;
      dataLeft  <= '0;
      dirRx     <= 1'b0;
      waitLoad  <= 1'b0;
      gapCnt    <= '0;
      csNR      <= 1'b1;
      doneR     <= 1'b0;
    end else begin
      doneR <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            opcReg    <= cmdOpcode;
            addrReg   <= cmdAddr;
            addrLeft  <= cmdAddrCnt;
            dummyLeft <= cmdDummyCnt;
            dataLeft  <= (cmdLen > LEN_CAP) ? LEN_CAP : cmdLen;
            dirRx     <= cmdRx;
            waitLoad  <= 1'b1;
            csNR      <= 1'b0;
            state     <= ST_OPC;
          end
        end
        ST_GAP: begin
          if (gapCnt == GAP_LAST) begin
            state <= ST_IDLE;
            doneR <= 1'b1;
          end else begin
            gapCnt <= gapCnt + GAP_W'(1);
          end
        end
        default: begin
          if (byteAvail) waitLoad <= 1'b0;
          if (dpStat.byteDone) begin
            addrLeft  <= nAddr;
            dummyLeft <= nDummy;
            dataLeft  <= nData;
            state     <= nextPh;
            if (nextPh == ST_GAP) begin
              csNR   <= 1'b1;
              gapCnt <= '0;
            end else begin
              waitLoad <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneR;
  assign csN  = csNR;

endmodule

// File: rtl/spinand_frame_engine.sv
module spinand_frame_engine
  import sfe_pkg::*;
#(
  parameter int SCLK_HALF = 2,
  parameter int LEN_W     = 12,
  parameter int MAX_LEN   = 2112,
  parameter int DUMMY_W   = 2,
  parameter int GAP_CYC   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmdValid,
  input  logic [7:0]         cmdOpcode,
  input  logic [1:0]         cmdAddrCnt,
  input  logic [23:0]        cmdAddr,
  input  logic [DUMMY_W-1:0] cmdDummyCnt,
  input  logic               cmdRx,
  input  logic [LEN_W-1:0]   cmdLen,
  input  logic [7:0]         txData,
  input  logic               txValid,
  output logic               txReady,
  output logic [7:0]         rxData,
  output logic               rxValid,
  output logic               busy,
  output logic               done,
  output logic               spiCsN,
  output logic               spiSclk,
  output logic               spiMosi,
  input  logic               spiMiso
);

  dpCmd_t  dpCmd;
  dpStat_t dpStat;

  sfe_ctrl #(
    .LEN_W  (LEN_W),
    .MAX_LEN(MAX_LEN),
    .DUMMY_W(DUMMY_W),
    .GAP_CYC(GAP_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmdValid   (cmdValid),
    .cmdOpcode  (cmdOpcode),
    .cmdAddrCnt (cmdAddrCnt),
    .cmdAddr    (cmdAddr),
    .cmdDummyCnt(cmdDummyCnt),
    .cmdRx      (cmdRx),
    .cmdLen     (cmdLen),
    .txData     (txData),
    .txValid    (txValid),
    .txReady    (txReady),
    .rxValid    (rxValid),
    .busy       (busy),
    .done       (done),
    .csN        (spiCsN),
    .dpCmd      (dpCmd),
    .dpStat     (dpStat)
  );

  sfe_shift #(
    .SCLK_HALF(SCLK_HALF)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .dpCmd  (dpCmd),
    .dpStat (dpStat),
    .spiMiso(spiMiso),
    .spiSclk(spiSclk),
    .spiMosi(spiMosi)
  );

  assign rxData = dpStat.rxByte;

endmodule

// File: rtl/sfe_checker.sv
module sfe_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic spiCsN,
  input logic spiSclk,
  input logic spiMosi,
  input logic rxValid,
  input logic txReady
);

  assert_idle_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spiCsN);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spiCsN |-> !spiSclk);

  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!spiCsN && spiSclk) |-> $stable(spiMosi));

  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spiCsN) |=> spiCsN);

  assert_dir_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rxValid && txReady));

endmodule

bind spinand_frame_engine sfe_checker u_sfe_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .done   (done),
  .spiCsN (spiCsN),
  .spiSclk(spiSclk),
  .spiMosi(spiMosi),
  .rxValid(rxValid),
  .txReady(txReady)
);

// File: tb/tb_spinand_frame_engine.sv
`timescale 1ns/1ps
module tb_spinand_frame_engine;

  localparam int CLK_PERIOD = 10;
  localparam int SCLK_HALF  = 2;
  localparam int MAX_LEN    = 2112;
  localparam int GAP_CYC    = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdOpcode = 8'h00;
  logic [1:0]  cmdAddrCnt = 2'd0;
  logic [23:0] cmdAddr = 24'h0;
  logic [1:0]  cmdDummyCnt = 2'd0;
  logic        cmdRx = 1'b0;
  logic [11:0] cmdLen = 12'd0;
  logic [7:0]  txData = 8'h00;
  logic        txValid = 1'b0;
  logic        txReady;
  logic [7:0]  rxData;
  logic        rxValid;
  logic        busy;
  logic        done;
  logic        spiCsN;
  logic        spiSclk;
  logic        spiMosi;
  logic        spiMiso = 1'b0;

  spinand_frame_engine dut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOpcode(cmdOpcode),
    .cmdAddrCnt(cmdAddrCnt), .cmdAddr(cmdAddr), .cmdDummyCnt(cmdDummyCnt),
    .cmdRx(cmdRx), .cmdLen(cmdLen), .txData(txData), .txValid(txValid),
    .txReady(txReady), .rxData(rxData), .rxValid(rxValid), .busy(busy),
    .done(done), .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi),
    .spiMiso(spiMiso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;

  function automatic logic [7:0] respByte(int i);
    return 8'(90 + i * 29);
  endfunction

  function automatic logic [7:0] txByteOf(int i);
    return 8'(i * 13 + 7);
  endfunction

  // device model: captures MOSI on rising SCLK, drives MISO after falling SCLK
  logic [7:0] cap [0:2199];
  logic [7:0] shIn = 8'h00;
  int  inFrame = 0, misoPos = 0, bitCnt = 0, byteCnt = 0, riseCnt = 0;
  int  csFalls = 0;
  time csRiseT = 0, lastGap = 0, t1 = 0, t2 = 0;

  always @(posedge spiSclk or negedge spiSclk or negedge spiCsN or posedge spiCsN) begin
    if (spiCsN === 1'b1) begin
      if (inFrame != 0) begin
        inFrame = 0;
        csRiseT = $time;
      end
    end else if (spiCsN === 1'b0) begin
      if (inFrame == 0) begin
        inFrame = 1;
        lastGap = $time - csRiseT;
        csFalls++;
        misoPos = 0; bitCnt = 0; byteCnt = 0; riseCnt = 0;
        spiMiso = respByte(0)[7];
      end else if (spiSclk === 1'b1) begin
        shIn = {shIn[6:0], spiMosi};
        riseCnt++;
        if (riseCnt == 1) t1 = $time;
        if (riseCnt == 2) t2 = $time;
        bitCnt++;
        if (bitCnt == 8) begin
          if (byteCnt < 2200) cap[byteCnt] = shIn;
          byteCnt++;
          bitCnt = 0;
        end
      end else begin
        misoPos++;
        spiMiso = respByte(misoPos / 8)[7 - (misoPos % 8)];
      end
    end
  end

  // write-data source
  int txCount = 0, stallWant = 0;
  int txIdx = 0, stallCnt = 0, stallSeen = 0, stallBad = 0;
  logic takeFlag = 1'b0;

  always @(negedge clk) begin
    if (!busy) begin
      txIdx = 0; stallCnt = 0; takeFlag = 1'b0;
    end else if (takeFlag) begin
      txIdx++;
    end
    if (txReady && stallCnt < stallWant) begin
      stallCnt++;
      stallSeen++;
      txValid = 1'b0;
      if (spiSclk !== 1'b0 || spiCsN !== 1'b0) stallBad++;
    end else begin
      txValid = (txIdx < txCount);
    end
    txData = txByteOf(txIdx);
    takeFlag = txReady && txValid;
  end

  // read-data collector
  logic [7:0] rxGot [0:4095];
  int rxCnt = 0;
  always @(negedge clk) begin
    if (rxValid) begin
      if (rxCnt < 4096) rxGot[rxCnt] = rxData;
      rxCnt++;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic [7:0] expMosi [0:2199];

  task automatic runCmd(string tag, logic [7:0] opc, int acnt, logic [23:0] addr,
                        int dcnt, bit rx, int len, int stall, bit spam);
    int n = 0, effLen, nPre, mis, fallsBefore, rxBase, stallSeenBefore, stallBadBefore, cnt;
    effLen = (len > MAX_LEN) ? MAX_LEN : len;
    expMosi[n++] = opc;
    for (int a = acnt - 1; a >= 0; a--) expMosi[n++] = 8'(addr >> (8 * a));
    for (int d = 0; d < dcnt; d++) expMosi[n++] = 8'hFF;
    nPre = n;
    for (int i = 0; i < effLen; i++) expMosi[n++] = rx ? 8'hFF : txByteOf(i);
    txCount = rx ? 0 : effLen;
    stallWant = stall;
    fallsBefore = csFalls;
    rxBase = rxCnt;
    stallSeenBefore = stallSeen;
    stallBadBefore = stallBad;
    // present at the current falling edge; accepted at the next rising edge
    cmdOpcode = opc; cmdAddrCnt = 2'(acnt); cmdAddr = addr;
    cmdDummyCnt = 2'(dcnt); cmdRx = rx; cmdLen = 12'(len);
    cmdValid = 1'b1;
    @(negedge clk);
    if (spam) begin
      cmdOpcode = 8'h55; cmdAddrCnt = 2'd3; cmdLen = 12'd9;
      repeat (20) @(negedge clk);
    end
    cmdValid = 1'b0;
    cnt = 0;
    while (!done && cnt < 100000) begin
      @(negedge clk);
      cnt++;
    end
    chk({tag, " done seen"}, done, 1);
    chk("R9 busy low in done cycle", busy, 0);
    chk("R9 cs high in done cycle", spiCsN, 1);
    chk("R7 one cs frame per command", csFalls - fallsBefore, 1);
    chk({tag, " byte count"}, byteCnt, n);
    chk("R2 opcode byte first", cap[0], opc);
    mis = 0;
    for (int i = 0; i < n && i < 2200; i++) if (cap[i] !== expMosi[i]) mis++;
    chk({tag, " mosi mismatches"}, mis, 0);
    chk({tag, " sclk rising edges"}, riseCnt, 8 * n);
    chk("R8 sclk period", t2 - t1, 2 * SCLK_HALF * CLK_PERIOD);
    if (rx) begin
      chk({tag, " rx byte count"}, rxCnt - rxBase, effLen);
      mis = 0;
      for (int k = 0; k < effLen; k++)
        if (rxGot[(rxBase + k) % 4096] !== respByte(nPre + k)) mis++;
      chk({tag, " rx mismatches"}, mis, 0);
    end
    if (stall > 0) begin
      chk("R5 stall cycles seen", stallSeen - stallSeenBefore, stall);
      chk("R5 sclk and cs held in stall", stallBad - stallBadBefore, 0);
    end
  endtask

  task automatic testReset();
    chk("R1 cs after reset", spiCsN, 1);
    chk("R1 sclk after reset", spiSclk, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 rxValid after reset", rxValid, 0);
    chk("R1 txReady after reset", txReady, 0);
  endtask

  task automatic testOpcodeOnly();
    runCmd("R11", 8'h06, 0, 24'h0, 0, 1'b0, 0, 0, 1'b0);
  endtask

  task automatic testRegRead();
    runCmd("R3", 8'h0F, 1, 24'h0000C0, 0, 1'b1, 1, 0, 1'b0);
  endtask

  task automatic testRegWrite();
    runCmd("R5", 8'h1F, 1, 24'h0000A0, 0, 1'b0, 1, 0, 1'b0);
  endtask

  task automatic testIdRead();
    runCmd("R6", 8'h9F, 0, 24'h0, 0, 1'b1, 3, 0, 1'b0);
  endtask

  task automatic testDummy();
    runCmd("R4", 8'h0B, 3, 24'h123456, 1, 1'b1, 16, 0, 1'b0);
    runCmd("R4", 8'h32, 2, 24'h000801, 3, 1'b0, 4, 0, 1'b0);
  endtask

  task automatic testStall();
    runCmd("R5", 8'h84, 2, 24'h000100, 0, 1'b0, 40, 25, 1'b0);
  endtask

  task automatic testBackToBack();
    runCmd("R7", 8'h13, 3, 24'h00ABCD, 0, 1'b0, 0, 0, 1'b0);
    runCmd("R7", 8'h0F, 1, 24'h0000C0, 0, 1'b1, 1, 0, 1'b0);
    chk("R7 cs high clocks between frames", lastGap / CLK_PERIOD, GAP_CYC + 1);
  endtask

  task automatic testIgnoreBusy();
    int f;
    runCmd("R9", 8'h0F, 1, 24'h0000B0, 0, 1'b1, 2, 0, 1'b1);
    f = csFalls;
    repeat (10) @(negedge clk);
    chk("R9 no frame from cmdValid while busy", csFalls - f, 0);
    chk("R9 idle after ignored request", busy, 0);
  endtask

  task automatic testClamp();
    runCmd("R10", 8'h03, 2, 24'h000000, 1, 1'b1, 2200, 0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testOpcodeOnly();
    testRegRead();
    testRegWrite();
    testIdRead();
    testDummy();
    testStall();
    testBackToBack();
    testIgnoreBusy();
    testClamp();
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule